// File: doc/BRIEF.md
# Low-Power DDR SDRAM Power-Up Command Sequencer

This block drives the command bus of a low-power DDR SDRAM on the controller side. It runs from reset until the memory is ready for normal traffic. Clock enable is held high the whole time. The block first issues NOP for a long power-up interval. It then issues a precharge of all banks, two auto-refresh commands and the two mode register loads (base and extended). Each command is followed by its own run of NOP cycles, and each run lasts exactly its minimum length. When the last interval ends, `init_done` rises and the bus stays at NOP from then on.

Every interval length is a parameter, and so are the two mode values. Two further parameters choose variants of the order. One decides whether the extended register is loaded before the base register. The other decides whether the two refreshes come right after the precharge interval or after the last mode-load interval. A synchronous reset, at any moment, sends the sequencer back to the start of the power-up interval.

The sequencer is a single state machine with a shared down-counter for the intervals. Its states are:
- ST_PWR_WAIT: power-up NOPs.
- ST_PRE, then ST_RP_WAIT.
- ST_REF_A, then ST_RFC_A_WAIT.
- ST_REF_B, then ST_RFC_B_WAIT.
- ST_MRS_1ST, then ST_MRD_1ST_WAIT.
- ST_MRS_2ND, then ST_MRD_2ND_WAIT.
- ST_READY.

The transitions are:
- ST_PWR_WAIT goes to ST_PRE when the counter reaches zero.
- Each command state goes to its wait state after one cycle and loads the counter at that edge.
- ST_RP_WAIT goes to ST_REF_A when the refreshes come early, or to ST_MRS_1ST when they come late.
- ST_RFC_A_WAIT goes to ST_REF_B.
- ST_RFC_B_WAIT goes to ST_MRS_1ST when the refreshes come early, or to ST_READY when they come late.
- ST_MRD_1ST_WAIT goes to ST_MRS_2ND.
- ST_MRD_2ND_WAIT goes to ST_READY when the refreshes come early, or to ST_REF_A when they come late.
- ST_READY holds until reset.
- A reset from any state goes to ST_PWR_WAIT.

Top module: `lpddr_init_seq`

## Requirements
- R1: `cke` is 1 in every cycle, including the cycles while `rst` is high.
- R2: The bus is encoded {cs_n,ras_n,cas_n,we_n}, and NOP is 0111 with `ba` and `addr` at zero. Cycle 0 is the cycle after the last clock edge that sampled `rst` high. Cycles 0 to PWRUP_CYC-1 carry NOP. Cycle PWRUP_CYC carries PRECHARGE ALL: the code 0010, `addr` bit 10 set, all other `addr` bits 0, and `ba` 0.
- R3: Exactly TRP_CYC NOP cycles follow the precharge before the next command.
- R4: Two AUTO REFRESH commands are issued: the code 0001 with `addr` 0 and `ba` 0, one cycle each. Each is followed by exactly TRFC_CYC NOP cycles.
- R5: The base mode load is the code 0000 with `ba` = 00 and `addr` = MODE_VAL for one cycle. It is followed by exactly TMRD_CYC NOP cycles.
- R6: The extended mode load is the code 0000 with `ba` = 10 and `addr` = EXT_VAL for one cycle. It is followed by exactly TMRD_CYC NOP cycles.
- R7: With EXT_FIRST = 0 the base load comes before the extended load. With EXT_FIRST = 1 the extended load comes first.
- R8: With REF_LATE = 0 both refreshes follow the precharge interval and come before the mode loads. With REF_LATE = 1 the mode loads follow the precharge interval directly, and the refreshes follow the second mode-load interval.
- R9: `init_done` rises in the cycle right after the last interval, and it is never high before both mode loads and both refreshes. It then stays high, and the bus carries NOP for as long as it is high.
- R10: A synchronous reset at any point clears `init_done` and puts NOP on the bus. After the reset is released the timing of R2 starts over.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Address bus |
| init_done | output | 1 | Sequence complete |

## Verification
The only input is `rst`, so the assertions assume only that it is sampled synchronously and may arrive at any cycle. They also assume that every interval parameter is at least one and that ADDR_W is at least 11, so that bit 10 exists. The stimulus keeps within this. It pulses reset for a random 1 to 4 cycles at random points inside and after the sequence, and it lets complete runs finish. Two instances cover both settings of the order parameters.

// File: rtl/lpinit_pkg.sv
package lpinit_pkg;

    typedef enum logic [3:0] {
        ST_PWR_WAIT,
        ST_PRE,
        ST_RP_WAIT,
        ST_REF_A,
        ST_RFC_A_WAIT,
        ST_REF_B,
        ST_RFC_B_WAIT,
        ST_MRS_1ST,
        ST_MRD_1ST_WAIT,
        ST_MRS_2ND,
        ST_MRD_2ND_WAIT,
        ST_READY
    } seq_state_t;

    // {cs_n, ras_n, cas_n, we_n}
    localparam logic [3:0] BUS_NOP = 4'b0111;
    localparam logic [3:0] BUS_PRE = 4'b0010;
    localparam logic [3:0] BUS_REF = 4'b0001;
    localparam logic [3:0] BUS_MRS = 4'b0000;

    function automatic int unsigned max4(int unsigned a, int unsigned b,
                                         int unsigned c, int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/lpinit_wait_ctr.sv
module lpinit_wait_ctr #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] rst_val,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= rst_val;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/lpinit_cmd_enc.sv
module lpinit_cmd_enc
    import lpinit_pkg::*;
#(
    parameter int unsigned ADDR_W    = 13,
    parameter int unsigned BA_W      = 2,
    parameter int unsigned MODE_VAL  = 'h32,
    parameter int unsigned EXT_VAL   = 'h20,
    parameter bit          EXT_FIRST = 1'b0
) (
    input  seq_state_t        state,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr,
    output logic              done
);
    localparam logic [ADDR_W-1:0] BASE_A   = ADDR_W'(MODE_VAL);
    localparam logic [ADDR_W-1:0] EXTD_A   = ADDR_W'(EXT_VAL);
    localparam logic [BA_W-1:0]   BASE_BA  = '0;
    localparam logic [BA_W-1:0]   EXTD_BA  = BA_W'(2);
    localparam logic [ADDR_W-1:0] PALL_A   = ADDR_W'(1) << 10;

    logic [ADDR_W-1:0] first_a, second_a;
    logic [BA_W-1:0]   first_ba, second_ba;

    generate
        if (EXT_FIRST) begin : g_ext_first
            assign first_a   = EXTD_A;
            assign first_ba  = EXTD_BA;
            assign second_a  = BASE_A;
            assign second_ba = BASE_BA;
        end else begin : g_base_first
            assign first_a   = BASE_A;
            assign first_ba  = BASE_BA;
            assign second_a  = EXTD_A;
            assign second_ba = EXTD_BA;
        end
    endgenerate

    logic [3:0] bus;

    always_comb begin
        bus  = BUS_NOP;
        ba   = '0;
        addr = '0;
        done = 1'b0;
        unique case (state)
            ST_PRE: begin
                bus  = BUS_PRE;
                addr = PALL_A;
            end
            ST_REF_A, ST_REF_B: bus = BUS_REF;
            ST_MRS_1ST: begin
                bus  = BUS_MRS;
                ba   = first_ba;
                addr = first_a;
            end
            ST_MRS_2ND: begin
                bus  = BUS_MRS;
                ba   = second_ba;
                addr = second_a;
            end
            ST_READY: done = 1'b1;
            ST_PWR_WAIT, ST_RP_WAIT, ST_RFC_A_WAIT, ST_RFC_B_WAIT,
            ST_MRD_1ST_WAIT, ST_MRD_2ND_WAIT: ;
            default: ;
        endcase
    end

    assign {cs_n, ras_n, cas_n, we_n} = bus;
endmodule

// File: rtl/lpddr_init_seq.sv
module lpddr_init_seq
    import lpinit_pkg::*;
#(
    parameter int unsigned PWRUP_CYC = 40000,
    parameter int unsigned TRP_CYC   = 4,
    parameter int unsigned TRFC_CYC  = 16,
    parameter int unsigned TMRD_CYC  = 2,
    parameter int unsigned ADDR_W    = 13,
    parameter int unsigned BA_W      = 2,
    parameter int unsigned MODE_VAL  = 'h32,
    parameter int unsigned EXT_VAL   = 'h20,
    parameter bit          EXT_FIRST = 1'b0,
    parameter bit          REF_LATE  = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr,
    output logic              init_done
);
    localparam int unsigned MAX_CYC = max4(PWRUP_CYC, TRP_CYC, TRFC_CYC, TMRD_CYC);
    localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] PWR_LD = CNT_W'(PWRUP_CYC - 1);
    localparam logic [CNT_W-1:0] RP_LD  = CNT_W'(TRP_CYC - 1);
    localparam logic [CNT_W-1:0] RFC_LD = CNT_W'(TRFC_CYC - 1);
    localparam logic [CNT_W-1:0] MRD_LD = CNT_W'(TMRD_CYC - 1);

    seq_state_t       state, state_nx;
    logic             wait_zero;
    logic             ld;
    logic [CNT_W-1:0] ld_val;

    // state register
    always_ff @(posedge clk) begin
        if (rst)
            state <= ST_PWR_WAIT;
        else
            state <= state_nx;
    end

    // next state and counter load
    always_comb begin
        state_nx = state;
        ld       = 1'b0;
        ld_val   = '0;
        unique case (state)
            ST_PWR_WAIT:     if (wait_zero) state_nx = ST_PRE;
            ST_PRE: begin
                ld = 1'b1; ld_val = RP_LD; state_nx = ST_RP_WAIT;
            end
            ST_RP_WAIT:      if (wait_zero) state_nx = REF_LATE ? ST_MRS_1ST : ST_REF_A;
            ST_REF_A: begin
                ld = 1'b1; ld_val = RFC_LD; state_nx = ST_RFC_A_WAIT;
            end
            ST_RFC_A_WAIT:   if (wait_zero) state_nx = ST_REF_B;
            ST_REF_B: begin
                ld = 1'b1; ld_val = RFC_LD; state_nx = ST_RFC_B_WAIT;
            end
            ST_RFC_B_WAIT:   if (wait_zero) state_nx = REF_LATE ? ST_READY : ST_MRS_1ST;
            ST_MRS_1ST: begin
                ld = 1'b1; ld_val = MRD_LD; state_nx = ST_MRD_1ST_WAIT;
            end
            ST_MRD_1ST_WAIT: if (wait_zero) state_nx = ST_MRS_2ND;
            ST_MRS_2ND: begin
                ld = 1'b1; ld_val = MRD_LD; state_nx = ST_MRD_2ND_WAIT;
            end
            ST_MRD_2ND_WAIT: if (wait_zero) state_nx = REF_LATE ? ST_REF_A : ST_READY;
            ST_READY:        state_nx = ST_READY;
            default:         state_nx = ST_PWR_WAIT;
        endcase
    end

    lpinit_wait_ctr #(.CNT_W(CNT_W)) u_wait (
        .clk      (clk),
        .rst      (rst),
        .rst_val  (PWR_LD),
        .load     (ld),
        .load_val (ld_val),
        .zero     (wait_zero)
    );

    // outputs
    lpinit_cmd_enc #(
        .ADDR_W    (ADDR_W),
        .BA_W      (BA_W),
        .MODE_VAL  (MODE_VAL),
        .EXT_VAL   (EXT_VAL),
        .EXT_FIRST (EXT_FIRST)
    ) u_enc (
        .state (state),
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .ba    (ba),
        .addr  (addr),
        .done  (init_done)
    );

    assign cke = 1'b1;
endmodule

// File: rtl/lpinit_chk.sv
module lpinit_chk #(
    parameter int unsigned PWRUP_CYC = 40000,
    parameter int unsigned ADDR_W    = 13,
    parameter int unsigned BA_W      = 2,
    parameter int unsigned MODE_VAL  = 'h32,
    parameter int unsigned EXT_VAL   = 'h20
) (
    input logic              clk,
    input logic              rst,
    input logic              cke,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [BA_W-1:0]   ba,
    input logic [ADDR_W-1:0] addr,
    input logic              init_done
);
    localparam int unsigned PW_W = $clog2(PWRUP_CYC + 1);

    logic [3:0] bus;
    assign bus = {cs_n, ras_n, cas_n, we_n};

    logic [PW_W-1:0] cyc;
    logic            base_seen, ext_seen;
    logic [1:0]      ref_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc       <= '0;
            base_seen <= 1'b0;
            ext_seen  <= 1'b0;
            ref_seen  <= '0;
        end else begin
            if (cyc != PW_W'(PWRUP_CYC)) cyc <= cyc + 1'b1;
            if (bus == 4'b0000 && ba == '0)        base_seen <= 1'b1;
            if (bus == 4'b0000 && ba == BA_W'(2))  ext_seen  <= 1'b1;
            if (bus == 4'b0001 && ref_seen != 2'd3) ref_seen <= ref_seen + 1'b1;
        end
    end

    a_r1_cke_high: assert property (@(posedge clk) cke);

    a_r2_pwrup_quiet: assert property (@(posedge clk) disable iff (rst)
        (cyc < PW_W'(PWRUP_CYC)) |-> bus == 4'b0111);

    a_r3_pre_spacing: assert property (@(posedge clk) disable iff (rst)
        (bus == 4'b0010) |=> bus == 4'b0111);

    a_r2_pre_all_banks: assert property (@(posedge clk) disable iff (rst)
        (bus == 4'b0010) |-> addr[10]);

    a_r4_ref_spacing: assert property (@(posedge clk) disable iff (rst)
        (bus == 4'b0001) |=> bus == 4'b0111);

    a_r5_mrs_values: assert property (@(posedge clk) disable iff (rst)
        (bus == 4'b0000) |-> ((ba == '0 && addr == ADDR_W'(MODE_VAL)) ||
                              (ba == BA_W'(2) && addr == ADDR_W'(EXT_VAL))));

    a_r6_mrs_spacing: assert property (@(posedge clk) disable iff (rst)
        (bus == 4'b0000) |=> bus == 4'b0111);

    a_r9_done_complete: assert property (@(posedge clk) disable iff (rst)
        init_done |-> (base_seen && ext_seen && ref_seen == 2'd2));

    a_r9_done_sticky: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done);

    a_r9_done_nop: assert property (@(posedge clk) disable iff (rst)
        init_done |-> bus == 4'b0111);

    a_r10_reset_clear: assert property (@(posedge clk)
        rst |=> (!init_done && bus == 4'b0111));
endmodule

bind lpddr_init_seq lpinit_chk #(
    .PWRUP_CYC (PWRUP_CYC),
    .ADDR_W    (ADDR_W),
    .BA_W      (BA_W),
    .MODE_VAL  (MODE_VAL),
    .EXT_VAL   (EXT_VAL)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cke       (cke),
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .ba        (ba),
    .addr      (addr),
    .init_done (init_done)
);

// File: tb/lpddr_init_seq_tb.sv
module lpddr_init_seq_tb;
    localparam int P0 = 200, RP0 = 3, RFC0 = 8, MRD0 = 2;
    localparam int M0 = 'h032, E0 = 'h041;
    localparam int P1 = 150, RP1 = 2, RFC1 = 5, MRD1 = 4;
    localparam int M1 = 'h123, E1 = 'h0A5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic        cke0, cs0, ras0, cas0, we0, dn0;
    logic [1:0]  ba0;
    logic [12:0] ad0;
    logic        cke1, cs1, ras1, cas1, we1, dn1;
    logic [1:0]  ba1;
    logic [12:0] ad1;

    lpddr_init_seq #(
        .PWRUP_CYC(P0), .TRP_CYC(RP0), .TRFC_CYC(RFC0), .TMRD_CYC(MRD0),
        .ADDR_W(13), .BA_W(2), .MODE_VAL(M0), .EXT_VAL(E0),
        .EXT_FIRST(1'b0), .REF_LATE(1'b0)
    ) u_dut (
        .clk(clk), .rst(rst), .cke(cke0), .cs_n(cs0), .ras_n(ras0),
        .cas_n(cas0), .we_n(we0), .ba(ba0), .addr(ad0), .init_done(dn0)
    );

    lpddr_init_seq #(
        .PWRUP_CYC(P1), .TRP_CYC(RP1), .TRFC_CYC(RFC1), .TMRD_CYC(MRD1),
        .ADDR_W(13), .BA_W(2), .MODE_VAL(M1), .EXT_VAL(E1),
        .EXT_FIRST(1'b1), .REF_LATE(1'b1)
    ) u_dut_alt (
        .clk(clk), .rst(rst), .cke(cke1), .cs_n(cs1), .ras_n(ras1),
        .cas_n(cas1), .we_n(we1), .ba(ba1), .addr(ad1), .init_done(dn1)
    );

    int  n_checks = 0;
    int  n_fail   = 0;
    int  n        = 0;
    bit  started  = 1'b0;
    bit  finished = 1'b0;

    always @(posedge clk) begin
        started <= 1'b1;
        if (rst) n <= 0;
        else     n <= n + 1;
    end

    // expected {done, cs_n,ras_n,cas_n,we_n, ba[1:0], addr[12:0]} in cycle n
    function automatic logic [19:0] exp_bus(int cyc, int p, int trp, int trfc,
                                            int tmrd, bit ext_first, bit ref_late,
                                            int mv, int ev, output string tag);
        logic [3:0]  c [5];
        logic [1:0]  b [5];
        logic [12:0] a [5];
        int          w [5];
        string       tg [5];
        int          t;
        int          k;
        logic [1:0]  b1st, b2nd;
        logic [12:0] a1st, a2nd;
        string       t1st, t2nd;
        b1st = ext_first ? 2'b10 : 2'b00;
        b2nd = ext_first ? 2'b00 : 2'b10;
        a1st = ext_first ? 13'(ev) : 13'(mv);
        a2nd = ext_first ? 13'(mv) : 13'(ev);
        t1st = ext_first ? "R6" : "R5";
        t2nd = ext_first ? "R5" : "R6";
        c[0] = 4'b0010; b[0] = 2'b00; a[0] = 13'h0400; w[0] = trp; tg[0] = "R3";
        k = ref_late ? 3 : 1;
        c[k] = 4'b0001; b[k] = 2'b00; a[k] = '0; w[k] = trfc; tg[k] = "R4";
        c[k+1] = 4'b0001; b[k+1] = 2'b00; a[k+1] = '0; w[k+1] = trfc; tg[k+1] = "R4";
        k = ref_late ? 1 : 3;
        c[k] = 4'b0000; b[k] = b1st; a[k] = a1st; w[k] = tmrd; tg[k] = t1st;
        c[k+1] = 4'b0000; b[k+1] = b2nd; a[k+1] = a2nd; w[k+1] = tmrd; tg[k+1] = t2nd;
        if (cyc < p) begin
            tag = "R2";
            return {1'b0, 4'b0111, 2'b00, 13'h0};
        end
        t = p;
        for (int i = 0; i < 5; i++) begin
            if (cyc == t) begin
                tag = (i == 0) ? "R2" : tg[i];
                return {1'b0, c[i], b[i], a[i]};
            end
            if (cyc <= t + w[i]) begin
                tag = tg[i];
                return {1'b0, 4'b0111, 2'b00, 13'h0};
            end
            t = t + 1 + w[i];
        end
        tag = "R9";
        return {1'b1, 4'b0111, 2'b00, 13'h0};
    endfunction

    task automatic check_bus(string who, logic [19:0] got, logic [19:0] exp,
                             string tag, bit alt);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s%s cycle %0d: got %h expected %h", tag, who,
                     alt ? " (order per R7 and R8)" : "", n, got, exp);
        end
    endtask

    task automatic check_cke(string who, logic v);
        n_checks++;
        if (v !== 1'b1) begin
            n_fail++;
            $display("FAIL R1 %s cke: got %b expected 1", who, v);
        end
    endtask

    always @(negedge clk) begin
        if (started && !finished) begin
            string       tg0, tg1;
            logic [19:0] e0, e1;
            e0 = exp_bus(n, P0, RP0, RFC0, MRD0, 1'b0, 1'b0, M0, E0, tg0);
            e1 = exp_bus(n, P1, RP1, RFC1, MRD1, 1'b1, 1'b1, M1, E1, tg1);
            if (rst) begin
                tg0 = "R10";
                tg1 = "R10";
            end
            check_bus("u_dut", {dn0, cs0, ras0, cas0, we0, ba0, ad0}, e0, tg0, 1'b0);
            check_bus("u_dut_alt", {dn1, cs1, ras1, cas1, we1, ba1, ad1}, e1, tg1, 1'b1);
            check_cke("u_dut", cke0);
            check_cke("u_dut_alt", cke1);
        end
    end

    task automatic summary();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    task automatic run_cycles(int k);
        repeat (k) @(posedge clk);
        #1;
    endtask

    task automatic pulse_reset(int len);
        rst = 1'b1;
        run_cycles(len);
        rst = 1'b0;
    endtask

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd20240607);
        // R10: reset state, then a full run of both orderings (R7, R8, R9)
        run_cycles(3);
        rst = 1'b0;
        run_cycles(260);
        // R10: directed reset right after PRECHARGE and right at init_done
        pulse_reset(1);
        run_cycles(P0 + 1);
        pulse_reset(2);
        run_cycles(P0 + RP0 + 2 * (RFC0 + 1) + 2 * (MRD0 + 1) + 1);
        pulse_reset(1);
        // R10: random reset pulses at random points
        for (int i = 0; i < 8; i++) begin
            run_cycles(int'($urandom_range(0, 250)));
            pulse_reset(int'($urandom_range(1, 4)));
        end
        // final full run to ready, held for a while (R9)
        run_cycles(300);
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected end of test");
        summary();
    end
endmodule